// File: doc/BRIEF.md
# Predicted-Reference Read-Retry Controller

This controller sequences page reads from a multi-level-cell flash array, where each cell holds two bits in one of four charge states (erased=11, first programmed=10, second=00, third=01) separated by three read reference levels. Stored charge leaks away over time, so the best reference drifts downward. Drift is similar across the pages of one block, so the controller keeps a small table with exactly one predicted 8-bit reference code per block. A read first applies that block's prediction. Each time the external ECC decoder reports the page as uncorrectable, the controller lowers the reference by a programmable step and reads again. This continues until decoding succeeds or a programmable retry limit runs out.

A periodic tick (nominally daily) starts a background pass. The pass walks every block in order, searches downward from the stored prediction with page 0 until the ECC decoder accepts the data, and writes the passing code back into the table. A foreground read always wins over the pass. If a request arrives while the pass is about to issue a read, the block being searched is abandoned, the request is served, and the pass continues at the following block. The array, the sensing and the decoder sit outside and are reached through a read strobe and an ECC result handshake.

Top module: `pred_retry_top`

## Requirements
- R1: While `rstN` is low at a clock edge, every table entry loads `cfgDefaultRef`, and `readStrobe`, `done`, `fail` and `bgActive` are low with `retryCount` = 0.
- R2: The first read of a foreground request applies the block's stored prediction on `refLevel` and raises `readStrobe` for exactly one cycle, with `readBlock`/`readPage` equal to the request.
- R3: On an ECC result with `eccPass`=0, the reference is lowered by `cfgStep` (a step of 0 acts as 1), `retryCount` rises by one and the page is read again, so a request issues `retryCount`+1 strobes.
- R4: The reference saturates at 0 and never wraps when a step is larger than the current code.
- R5: On an ECC result with `eccPass`=1 in the foreground, `done` pulses for one cycle in the cycle after that result, with `refLevel` and `retryCount` holding the passing values.
- R6: If the read at `retryCount` = `cfgMaxRetry` also fails, `fail` pulses for one cycle instead of another retry, with `retryCount` = `cfgMaxRetry`; a pass at exactly that count still gives `done`.
- R7: A `tick` while no pass is pending starts a background pass over blocks 0 to N-1. For each block, a passing code is written to the table, and a search that hits the retry limit leaves the entry unchanged. `bgActive` is high for the whole pass.
- R8: Background reads never pulse `done` or `fail`.
- R9: A request seen while the pass is at its issue point aborts that block's search (its entry is unchanged) without a strobe. The request is served next, and the pass resumes at the next block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgDefaultRef | input | 8 | Reference code loaded into every table entry at reset |
| cfgStep | input | 8 | Decrement per retry (0 treated as 1) |
| cfgMaxRetry | input | 4 | Retries allowed before failing |
| reqValid | input | 1 | Foreground read request, held until accepted |
| reqBlock | input | 3 | Requested block |
| reqPage | input | 6 | Requested page |
| reqReady | output | 1 | Request is taken at the next edge if reqValid is high |
| tick | input | 1 | Periodic trigger for the background pass |
| eccValid | input | 1 | ECC result is present |
| eccPass | input | 1 | ECC result: 1 correctable, 0 uncorrectable |
| readStrobe | output | 1 | One-cycle pulse starting a page read |
| readBlock | output | 3 | Block of the current read |
| readPage | output | 6 | Page of the current read |
| refLevel | output | 8 | Reference code to apply |
| retryCount | output | 4 | Retries made by the current or last operation |
| done | output | 1 | Foreground read succeeded (one-cycle pulse) |
| fail | output | 1 | Foreground read exhausted its retries (one-cycle pulse) |
| bgActive | output | 1 | Background pass in progress |

## Verification
A request is taken at the edge after `reqValid` is seen with `reqReady` high. `readStrobe` follows in the next cycle. The ECC result is accepted no earlier than the edge after the strobe, and `done` or `fail` appears in the cycle after the edge that took a result. The bench's ECC responder therefore answers one cycle after each strobe and compares `refLevel` against a per-block pass threshold. All outputs are sampled at falling edges, one full half-period after the registers update. Preemption is placed by counting edges from the tick: two edges move the controller into the background issue state, and the request is raised exactly there. Background results are read back through later foreground reads whose first strobe shows the written code.

// File: rtl/pred_retry_pkg.sv
package pred_retry_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} ctrl_state_t;

  typedef struct packed {
    logic loadFg;
    logic loadBg;
    logic stepDown;
    logic writeBack;
    logic pulseDone;
    logic pulseFail;
  } dp_cmd_t;
endpackage

// File: rtl/pred_retry_dp.sv
module pred_retry_dp
  import pred_retry_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int PAGE_W = 6,
  parameter int REF_W = 8,
  parameter int CNT_W = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REF_W-1:0] cfgDefaultRef,
  input  logic [REF_W-1:0] cfgStep,
  input  logic [CNT_W-1:0] cfgMaxRetry,
  input  dp_cmd_t          cmd,
  input  logic [BLK_W-1:0] reqBlock,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [BLK_W-1:0] bgBlock,
  output logic [BLK_W-1:0] curBlock,
  output logic [PAGE_W-1:0] curPage,
  output logic [REF_W-1:0] curRef,
  output logic [CNT_W-1:0] retryCnt,
  output logic             atLimit,
  output logic             doneQ,
  output logic             failQ
);
  logic [REF_W-1:0] predTab [NUM_BLOCKS];
  logic [REF_W-1:0] effStep;
  logic [REF_W-1:0] lowered;

  assign effStep = (cfgStep == '0) ? REF_W'(1) : cfgStep;
  assign lowered = (curRef > effStep) ? (curRef - effStep) : '0;
  assign atLimit = (retryCnt >= cfgMaxRetry);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BLOCKS; i++) predTab[i] <= cfgDefaultRef;
    end else if (cmd.writeBack) begin
      predTab[curBlock] <= curRef;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBlock <= '0;
      curPage  <= '0;
      curRef   <= '0;
      retryCnt <= '0;
      doneQ    <= 1'b0;
      failQ    <= 1'b0;
    end else begin
      doneQ <= cmd.pulseDone;
      failQ <= cmd.pulseFail;
      if (cmd.loadFg) begin
        curBlock <= reqBlock;
        curPage  <= reqPage;
        curRef   <= predTab[reqBlock];
        retryCnt <= '0;
      end else if (cmd.loadBg) begin
        curBlock <= bgBlock;
        curPage  <= '0;
        curRef   <= predTab[bgBlock];
        retryCnt <= '0;
      end else if (cmd.stepDown) begin
        curRef   <= lowered;
        retryCnt <= retryCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pred_retry_ctrl.sv
module pred_retry_ctrl
  import pred_retry_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             tick,
  input  logic             eccValid,
  input  logic             eccPass,
  input  logic             atLimit,
  output dp_cmd_t          cmd,
  output logic [BLK_W-1:0] bgBlock,
  output logic             readStrobe,
  output logic             reqReady,
  output logic             bgActive
);
  ctrl_state_t state, stateNxt;
  logic bgMode, bgModeNxt;
  logic bgPending;
  logic advBg;
  logic preempt;

  assign preempt    = (state == ST_ISSUE) && bgMode && reqValid;
  assign readStrobe = (state == ST_ISSUE) && !preempt;
  assign reqReady   = (state == ST_IDLE) || ((state == ST_ISSUE) && bgMode);
  assign bgActive   = bgPending;

  always_comb begin
    cmd       = '0;
    stateNxt  = state;
    bgModeNxt = bgMode;
    advBg     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          cmd.loadFg = 1'b1;
          bgModeNxt  = 1'b0;
          stateNxt   = ST_ISSUE;
        end else if (bgPending) begin
          cmd.loadBg = 1'b1;
          bgModeNxt  = 1'b1;
          stateNxt   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (preempt) begin
          advBg      = 1'b1;
          cmd.loadFg = 1'b1;
          bgModeNxt  = 1'b0;
        end else begin
          stateNxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (eccValid) begin
          if (eccPass) begin
            stateNxt = ST_IDLE;
            if (bgMode) begin
              cmd.writeBack = 1'b1;
              advBg         = 1'b1;
            end else begin
              cmd.pulseDone = 1'b1;
            end
          end else if (atLimit) begin
            stateNxt = ST_IDLE;
            if (bgMode) advBg = 1'b1;
            else cmd.pulseFail = 1'b1;
          end else begin
            cmd.stepDown = 1'b1;
            stateNxt     = ST_ISSUE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bgMode    <= 1'b0;
      bgPending <= 1'b0;
      bgBlock   <= '0;
    end else begin
      state  <= stateNxt;
      bgMode <= bgModeNxt;
      if (advBg) begin
        if (bgBlock == BLK_W'(NUM_BLOCKS - 1)) begin
          bgPending <= 1'b0;
          bgBlock   <= '0;
        end else begin
          bgBlock <= bgBlock + BLK_W'(1);
        end
      end else if (tick && !bgPending) begin
        bgPending <= 1'b1;
        bgBlock   <= '0;
      end
    end
  end
endmodule

// File: rtl/pred_retry_top.sv
module pred_retry_top
  import pred_retry_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int PAGE_W = 6,
  parameter int REF_W = 8,
  parameter int CNT_W = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REF_W-1:0]  cfgDefaultRef,
  input  logic [REF_W-1:0]  cfgStep,
  input  logic [CNT_W-1:0]  cfgMaxRetry,
  input  logic              reqValid,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              reqReady,
  input  logic              tick,
  input  logic              eccValid,
  input  logic              eccPass,
  output logic              readStrobe,
  output logic [BLK_W-1:0]  readBlock,
  output logic [PAGE_W-1:0] readPage,
  output logic [REF_W-1:0]  refLevel,
  output logic [CNT_W-1:0]  retryCount,
  output logic              done,
  output logic              fail,
  output logic              bgActive
);
  dp_cmd_t          cmd;
  logic [BLK_W-1:0] bgBlock;
  logic             atLimit;

  pred_retry_ctrl #(.NUM_BLOCKS(NUM_BLOCKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tick(tick),
    .eccValid(eccValid), .eccPass(eccPass), .atLimit(atLimit),
    .cmd(cmd), .bgBlock(bgBlock), .readStrobe(readStrobe),
    .reqReady(reqReady), .bgActive(bgActive)
  );

  pred_retry_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGE_W(PAGE_W), .REF_W(REF_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgDefaultRef(cfgDefaultRef), .cfgStep(cfgStep),
    .cfgMaxRetry(cfgMaxRetry), .cmd(cmd), .reqBlock(reqBlock), .reqPage(reqPage),
    .bgBlock(bgBlock), .curBlock(readBlock), .curPage(readPage), .curRef(refLevel),
    .retryCnt(retryCount), .atLimit(atLimit), .doneQ(done), .failQ(fail)
  );
endmodule

// File: rtl/pred_retry_chk.sv
module pred_retry_chk #(
  parameter int REF_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             readStrobe,
  input logic             eccValid,
  input logic             eccPass,
  input logic             done,
  input logic             fail,
  input logic [REF_W-1:0] refLevel,
  input logic [CNT_W-1:0] retryCount,
  input logic [CNT_W-1:0] cfgMaxRetry
);
  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> !readStrobe);

  // R5
  done_after_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(eccValid && eccPass));

  // R6
  fail_at_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (retryCount == cfgMaxRetry) && $past(eccValid && !eccPass));

  // R5 R6
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

  // R3
  retry_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retryCount != $past(retryCount)) |->
      (retryCount == $past(retryCount) + CNT_W'(1)) || (retryCount == '0));

  // R4
  ref_nonincr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retryCount == $past(retryCount) + CNT_W'(1)) |-> (refLevel <= $past(refLevel)));
endmodule

bind pred_retry_top pred_retry_chk #(.REF_W(REF_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .readStrobe(readStrobe), .eccValid(eccValid),
  .eccPass(eccPass), .done(done), .fail(fail), .refLevel(refLevel),
  .retryCount(retryCount), .cfgMaxRetry(cfgMaxRetry)
);

// File: tb/pred_retry_tb.sv
module pred_retry_top_tb_top;
  localparam int NB = 8;

  logic       clk, rstN;
  logic [7:0] cfgDefaultRef, cfgStep;
  logic [3:0] cfgMaxRetry;
  logic       reqValid;
  logic [2:0] reqBlock;
  logic [5:0] reqPage;
  logic       reqReady, tick, eccValid, eccPass, readStrobe;
  logic [2:0] readBlock;
  logic [5:0] readPage;
  logic [7:0] refLevel;
  logic [3:0] retryCount;
  logic       done, fail, bgActive;

  int checks = 0;
  int failures = 0;
  int thr [NB];
  int strobeCnt, firstRef, lastBlk, lastPage;
  bit pend;
  bit finished = 0;

  // vector: block, step, maxRetry, expDone, expRetry, expRef
  localparam int VEC [7][6] = '{
    '{0, 10,  8, 1, 0, 200},
    '{1, 10,  8, 1, 2, 180},
    '{2, 10,  8, 0, 8, 120},
    '{3,  0,  8, 1, 3, 197},
    '{4, 120, 8, 1, 2,   0},
    '{5, 100, 1, 0, 1, 100},
    '{6, 10,  8, 1, 8, 120}
  };

  pred_retry_top dut_i (
    .clk(clk), .rstN(rstN), .cfgDefaultRef(cfgDefaultRef), .cfgStep(cfgStep),
    .cfgMaxRetry(cfgMaxRetry), .reqValid(reqValid), .reqBlock(reqBlock),
    .reqPage(reqPage), .reqReady(reqReady), .tick(tick), .eccValid(eccValid),
    .eccPass(eccPass), .readStrobe(readStrobe), .readBlock(readBlock),
    .readPage(readPage), .refLevel(refLevel), .retryCount(retryCount),
    .done(done), .fail(fail), .bgActive(bgActive)
  );

  initial begin
    clk = 0;
    forever #5 clk = ~clk;
  end

  // ECC responder: answers one cycle after each strobe
  initial begin
    eccValid = 0; eccPass = 0; pend = 0; strobeCnt = 0;
    firstRef = 0; lastBlk = 0; lastPage = 0;
    forever begin
      @(negedge clk);
      #1;
      if (pend) begin
        eccValid = 1;
        eccPass = (int'(refLevel) <= thr[readBlock]);
        pend = 0;
      end else begin
        eccValid = 0;
      end
      if (readStrobe) begin
        pend = 1;
        strobeCnt++;
        if (strobeCnt == 1) firstRef = refLevel;
        lastBlk = readBlock;
        lastPage = readPage;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(int def);
    rstN = 0; cfgDefaultRef = 8'(def); reqValid = 0; tick = 0;
    reqBlock = 0; reqPage = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic doRead(int blk, int page, output int gDone, output int gFail,
                        output int gRetry, output int gRef);
    strobeCnt = 0;
    reqBlock = 3'(blk); reqPage = 6'(page); reqValid = 1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 400; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    gDone = done; gFail = fail; gRetry = retryCount; gRef = refLevel;
    @(negedge clk);
  endtask

  task automatic waitBg();
    int spurious = 0;
    for (int i = 0; i < 2000; i++) begin
      if (!bgActive) break;
      if (done || fail) spurious++;
      @(negedge clk);
    end
    chk("R8 no done/fail during background", spurious, 0);
    chk("R7 background pass ends", bgActive, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d, f, r, v;
    thr = '{255, 185, 100, 197, 0, 50, 120, 255};
    cfgStep = 10; cfgMaxRetry = 8;

    // R1: reset state, default load
    doReset(90);
    chk("R1 strobe low", readStrobe, 0);
    chk("R1 done low", done, 0);
    chk("R1 fail low", fail, 0);
    chk("R1 bgActive low", bgActive, 0);
    chk("R1 retryCount zero", retryCount, 0);
    doRead(0, 3, d, f, r, v);
    chk("R1 default loaded into table", firstRef, 90);
    chk("R2 strobe page", lastPage, 3);

    // vector walk: foreground retry behaviour
    doReset(200);
    for (int i = 0; i < 7; i++) begin
      cfgStep = 8'(VEC[i][1]);
      cfgMaxRetry = 4'(VEC[i][2]);
      doRead(VEC[i][0], i + 1, d, f, r, v);
      chk("R2 first ref is prediction", firstRef, 200);
      chk("R2 read block", lastBlk, VEC[i][0]);
      chk("R5 done flag", d, VEC[i][3]);
      chk("R6 fail flag", f, 1 - VEC[i][3]);
      chk("R3 retry count", r, VEC[i][4]);
      chk("R4 final reference", v, VEC[i][5]);
      chk("R3 strobes per request", strobeCnt, VEC[i][4] + 1);
    end

    // R7: background pass writes passing codes, keeps failing ones
    cfgStep = 10; cfgMaxRetry = 8;
    tick = 1; @(negedge clk); tick = 0;
    @(negedge clk);
    chk("R7 bgActive after tick", bgActive, 1);
    waitBg();
    doRead(1, 0, d, f, r, v);
    chk("R7 block1 learned ref", firstRef, 180);
    chk("R7 block1 no retry", r, 0);
    doRead(6, 0, d, f, r, v);
    chk("R7 block6 learned ref", firstRef, 120);
    doRead(3, 0, d, f, r, v);
    chk("R7 block3 learned ref", firstRef, 190);
    doRead(2, 0, d, f, r, v);
    chk("R7 block2 unchanged after failed search", firstRef, 200);
    chk("R6 block2 still fails", f, 1);

    // R9: preemption of the background pass
    doReset(200);
    for (int i = 0; i < NB; i++) thr[i] = 150;
    tick = 1; @(negedge clk); tick = 0;
    @(negedge clk);
    doRead(7, 9, d, f, r, v);
    chk("R9 preempting read done", d, 1);
    chk("R9 preempting read retries", r, 5);
    chk("R9 preempt issued no background strobe", strobeCnt, 6);
    waitBg();
    doRead(0, 0, d, f, r, v);
    chk("R9 aborted block0 unchanged", firstRef, 200);
    doRead(1, 0, d, f, r, v);
    chk("R9 pass resumed at block1", firstRef, 150);
    doRead(7, 0, d, f, r, v);
    chk("R9 pass reached block7", firstRef, 150);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule